// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers interrupt requests from up to 31 sources and drives a single interrupt line to one processor. Source IDs run from 1 to `NUM_SRC`. ID 0 is reserved and means "nothing to serve". Software reaches the core through a plain 32-bit register bus with an address, a write strobe, a read strobe, write data and registered read data. Through this bus it programs a 3-bit priority for each source, a bitmap of enabled sources and a 3-bit threshold. It then serves interrupts by reading a claim register and writing a complete register.

Each source passes through a small gateway state machine with three states. `GW_IDLE` waits for a request. A level source requests while its input is high, and an edge source requests on a rising edge of its input. The request moves the gateway to `GW_PEND`. A claim read that names the source moves it from `GW_PEND` to `GW_SERV`. A completion write naming the source moves it from `GW_SERV` back to `GW_IDLE`. Gateways in `GW_PEND` take part in arbitration when their source is enabled and its priority is strictly above the threshold. The highest priority wins, and on a tie the lowest ID wins.

The source inputs are assumed to be synchronous to `clk`. Sources whose bit is set in `EDGE_MASK` are edge-triggered. By default these are IDs 28 to 31.

Top module: `plic_core`

## Requirements
- R1: After reset, `irq_o` is low, every priority, the enable word and the threshold read 0, and a claim read returns 0.
- R2: The priority register of source n sits at byte address 4·n. Only bits [2:0] are stored, and the upper bits of a read return 0. Writes to the priority of ID 0 are ignored, and that register reads 0.
- R3: The enable word sits at address 0x080, with bit n enabling source n. Bit 0 and bits above `NUM_SRC` are not writable and read 0.
- R4: A source whose priority is 0, or whose enable bit is clear, never wins arbitration and never raises `irq_o`. Enabling a pending source lets it win.
- R5: The threshold sits at address 0x0C0. A pending source takes part only when its priority is strictly greater than the threshold, so a threshold of 7 masks every source.
- R6: Among eligible sources the highest priority wins. Equal priorities go to the lowest ID.
- R7: A read of address 0x0C4 returns the current winner's ID, or 0 when there is none, and moves that source from `GW_PEND` to `GW_SERV` at the same clock edge.
- R8: A source in `GW_SERV` cannot become pending again. A level request still held high becomes pending one cycle after its completion.
- R9: A write of ID n to address 0x0C4 completes source n whatever ID was claimed last.
- R10: A completion naming ID 0, an ID above `NUM_SRC`, or a source whose enable bit is clear has no effect. That source stays in `GW_SERV`.
- R11: `irq_o` is registered. It goes high one cycle after an eligible pending source appears, and goes low one cycle after the last one disappears.
- R12: An edge source becomes pending only on a 0-to-1 transition of its input. An input held high does not re-pend after completion, and a rising edge that arrives while the source is in `GW_SERV` is lost.
- R13: When the write and read strobes are both high, only the write takes place. In particular, a claim read is not performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt requests; bit n is source ID n |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | External interrupt request to the processor |

## Verification
The delicate overlap is a claim read landing in the same cycle as a new request reaching another gateway. The claim has to return the winner computed from the state before that edge, while the newcomer enters `GW_PEND` at the same edge. The bench raises a higher-priority source in the very cycle it strobes the claim. It expects the older, lower-priority ID in the read data, `irq_o` to stay high without a gap, and the next claim to return the newcomer. It then counts the cycles until `irq_o` falls once nothing is left pending.

// File: rtl/plic_core_pkg.sv
package plic_core_pkg;

    localparam int PRIO_W   = 3;
    localparam int DATA_W   = 32;

    // word indices (byte address / 4) of the control registers
    localparam int WORD_ENABLE = 32;   // 0x080
    localparam int WORD_THRESH = 48;   // 0x0C0
    localparam int WORD_CLAIM  = 49;   // 0x0C4

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_SERV = 2'd2
    } gw_state_e;

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
    import plic_core_pkg::*;
#(
    parameter bit IS_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic claim_i,
    input  logic cmpl_i,
    output logic pend_o,
    output logic serv_o
);

    logic      trig;
    gw_state_e state_q;
    gw_state_e state_d;

    generate
        if (IS_EDGE) begin : g_edge
            logic req_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    req_q <= 1'b0;
                end else begin
                    req_q <= req_i;
                end
            end
            assign trig = req_i & ~req_q;
        end else begin : g_level
            assign trig = req_i;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (trig)    state_d = GW_PEND;
            GW_PEND: if (claim_i) state_d = GW_SERV;
            GW_SERV: if (cmpl_i)  state_d = GW_IDLE;
            default:              state_d = GW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend_o = 1'b0;
        serv_o = 1'b0;
        unique case (state_q)
            GW_PEND: pend_o = 1'b1;
            GW_SERV: serv_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter
    import plic_core_pkg::*;
#(
    parameter int ID_W  = 5,
    parameter int SLOTS = 32
) (
    input  logic [SLOTS-1:0]        pend_i,
    input  logic [SLOTS-1:0]        en_i,
    input  logic [SLOTS*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]       thr_i,
    output logic [ID_W-1:0]         win_id_o,
    output logic                    win_valid_o
);

    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_id;

    // Scanning upward with a strict compare keeps the lowest ID on ties;
    // starting from the threshold excludes priority 0 and masked levels.
    always_comb begin
        best_p  = thr_i;
        best_id = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (pend_i[i] && en_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
                best_p  = prio_i[i*PRIO_W +: PRIO_W];
                best_id = ID_W'(i);
            end
        end
    end

    assign win_id_o    = best_id;
    assign win_valid_o = (best_id != '0);

endmodule

// File: rtl/plic_regs.sv
module plic_regs
    import plic_core_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int ID_W    = 5,
    parameter int SLOTS   = 32,
    parameter int ADDR_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic                    bus_we_i,
    input  logic                    bus_re_i,
    input  logic [DATA_W-1:0]       bus_wdata_i,
    output logic [DATA_W-1:0]       bus_rdata_o,
    input  logic [ID_W-1:0]         win_id_i,
    input  logic                    win_valid_i,
    output logic [SLOTS*PRIO_W-1:0] prio_o,
    output logic [SLOTS-1:0]        en_o,
    output logic [PRIO_W-1:0]       thr_o,
    output logic [SLOTS-1:0]        claim_o,
    output logic [SLOTS-1:0]        cmpl_o
);

    localparam int WA_W = ADDR_W - 2;
    localparam logic [SLOTS-1:0] SRC_MASK = SLOTS'(((64'd1 << (NUM_SRC + 1)) - 64'd1) & ~64'd1);

    logic [WA_W-1:0]         word;
    logic                    aligned;
    logic                    hit_prio, hit_en, hit_thr, hit_claim;
    logic                    do_wr, do_rd;
    logic [ID_W-1:0]         prio_idx;
    logic [ID_W-1:0]         cmpl_id;
    logic                    cmpl_ok;
    logic [SLOTS*PRIO_W-1:0] prio_q;
    logic [SLOTS-1:0]        en_q;
    logic [PRIO_W-1:0]       thr_q;
    logic [DATA_W-1:0]       rd_mux;
    logic [DATA_W-1:0]       rdata_q;

    assign word      = bus_addr_i[ADDR_W-1:2];
    assign aligned   = (bus_addr_i[1:0] == 2'b00);
    assign hit_prio  = aligned && (int'(word) < SLOTS);
    assign hit_en    = aligned && (word == WA_W'(WORD_ENABLE));
    assign hit_thr   = aligned && (word == WA_W'(WORD_THRESH));
    assign hit_claim = aligned && (word == WA_W'(WORD_CLAIM));
    assign prio_idx  = word[ID_W-1:0];

    // write wins when both strobes are raised
    assign do_wr = bus_we_i;
    assign do_rd = bus_re_i && !bus_we_i;

    // priority storage, ID 0 and unused slots stay zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (do_wr && hit_prio) begin
            for (int i = 1; i < SLOTS; i++) begin
                if ((int'(prio_idx) == i) && (i <= NUM_SRC)) begin
                    prio_q[i*PRIO_W +: PRIO_W] <= bus_wdata_i[PRIO_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            thr_q <= '0;
        end else if (do_wr) begin
            if (hit_en)  en_q  <= bus_wdata_i[SLOTS-1:0] & SRC_MASK;
            if (hit_thr) thr_q <= bus_wdata_i[PRIO_W-1:0];
        end
    end

    // completion decode: the ID must fit and name an enabled source
    assign cmpl_id = bus_wdata_i[ID_W-1:0];
    assign cmpl_ok = do_wr && hit_claim && (bus_wdata_i[DATA_W-1:ID_W] == '0);
    assign cmpl_o  = cmpl_ok ? (en_q & (SLOTS'(1) << cmpl_id)) : '0;

    // claim decode: the current winner moves into service
    assign claim_o = (do_rd && hit_claim && win_valid_i) ? (SLOTS'(1) << win_id_i) : '0;

    always_comb begin
        rd_mux = '0;
        if (hit_prio) begin
            rd_mux[PRIO_W-1:0] = prio_q[prio_idx*PRIO_W +: PRIO_W];
        end else if (hit_en) begin
            rd_mux[SLOTS-1:0] = en_q;
        end else if (hit_thr) begin
            rd_mux[PRIO_W-1:0] = thr_q;
        end else if (hit_claim) begin
            rd_mux[ID_W-1:0] = win_id_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (do_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata_o = rdata_q;
    assign prio_o      = prio_q;
    assign en_o        = en_q;
    assign thr_o       = thr_q;

endmodule

// File: rtl/plic_core.sv
module plic_core
    import plic_core_pkg::*;
#(
    parameter int          NUM_SRC   = 31,
    parameter int          ADDR_W    = 12,
    parameter logic [31:0] EDGE_MASK = 32'hF000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_we_i,
    input  logic               bus_re_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o
);

    localparam int ID_W  = $clog2(NUM_SRC + 1);
    localparam int SLOTS = 1 << ID_W;

    logic [SLOTS-1:0]        pend_vec;
    logic [SLOTS-1:0]        serv_vec;
    logic [SLOTS-1:0]        en_vec;
    logic [SLOTS-1:0]        claim_vec;
    logic [SLOTS-1:0]        cmpl_vec;
    logic [SLOTS*PRIO_W-1:0] prio_flat;
    logic [PRIO_W-1:0]       thr;
    logic [ID_W-1:0]         win_id;
    logic                    win_valid;
    logic                    irq_q;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_src
            if ((g >= 1) && (g <= NUM_SRC)) begin : g_gw
                plic_gateway #(
                    .IS_EDGE (EDGE_MASK[g])
                ) u_gw (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .req_i   (src_i[g]),
                    .claim_i (claim_vec[g]),
                    .cmpl_i  (cmpl_vec[g]),
                    .pend_o  (pend_vec[g]),
                    .serv_o  (serv_vec[g])
                );
            end else begin : g_none
                assign pend_vec[g] = 1'b0;
                assign serv_vec[g] = 1'b0;
            end
        end
    endgenerate

    plic_regs #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W),
        .SLOTS   (SLOTS),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_re_i    (bus_re_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .win_id_i    (win_id),
        .win_valid_i (win_valid),
        .prio_o      (prio_flat),
        .en_o        (en_vec),
        .thr_o       (thr),
        .claim_o     (claim_vec),
        .cmpl_o      (cmpl_vec)
    );

    plic_arbiter #(
        .ID_W  (ID_W),
        .SLOTS (SLOTS)
    ) u_arb (
        .pend_i      (pend_vec),
        .en_i        (en_vec),
        .prio_i      (prio_flat),
        .thr_i       (thr),
        .win_id_o    (win_id),
        .win_valid_o (win_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= win_valid;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk
    import plic_core_pkg::*;
#(
    parameter int ID_W   = 5,
    parameter int SLOTS  = 32,
    parameter int ADDR_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    irq_o,
    input logic [ADDR_W-1:0]       bus_addr_i,
    input logic                    bus_we_i,
    input logic                    bus_re_i,
    input logic [DATA_W-1:0]       bus_wdata_i,
    input logic [DATA_W-1:0]       bus_rdata_o,
    input logic [SLOTS-1:0]        pend_vec,
    input logic [SLOTS-1:0]        serv_vec,
    input logic [SLOTS-1:0]        en_vec,
    input logic [SLOTS*PRIO_W-1:0] prio_flat,
    input logic [PRIO_W-1:0]       thr,
    input logic [ID_W-1:0]         win_id,
    input logic                    win_valid
);

    logic            at_claim;
    logic            rd_claim;
    logic            wr_claim;
    logic [ID_W-1:0] wr_id;

    assign at_claim = (bus_addr_i == ADDR_W'(WORD_CLAIM * 4));
    assign rd_claim = at_claim && bus_re_i && !bus_we_i;
    assign wr_claim = at_claim && bus_we_i && (bus_wdata_i[DATA_W-1:ID_W] == '0);
    assign wr_id    = bus_wdata_i[ID_W-1:0];

    // R4 R5 R6
    winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend_vec[win_id] && en_vec[win_id] &&
                       (prio_flat[win_id*PRIO_W +: PRIO_W] > thr)));

    // R7
    claim_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_claim && win_valid) |=> ($countones(serv_vec) == $past($countones(serv_vec)) + 1));

    // R7
    empty_claim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_claim && !win_valid) |=> (bus_rdata_o == '0));

    // R10
    ignored_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_claim && !en_vec[wr_id]) |=> (serv_vec == $past(serv_vec)));

    // R11
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(pend_vec) != '0));

endmodule

bind plic_core plic_core_chk #(
    .ID_W   (ID_W),
    .SLOTS  (SLOTS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_o       (irq_o),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_re_i    (bus_re_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pend_vec    (pend_vec),
    .serv_vec    (serv_vec),
    .en_vec      (en_vec),
    .prio_flat   (prio_flat),
    .thr         (thr),
    .win_id      (win_id),
    .win_valid   (win_valid)
);

// File: tb/test_plic_core.sv
`timescale 1ns/1ps
module test_plic_core;

    localparam int NUM_SRC = 31;
    localparam int ADDR_W  = 12;
    localparam logic [ADDR_W-1:0] A_ENA = 12'h080;
    localparam logic [ADDR_W-1:0] A_THR = 12'h0C0;
    localparam logic [ADDR_W-1:0] A_CLM = 12'h0C4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_SRC:1]  src = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              we = 1'b0;
    logic              re = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    plic_core #(
        .NUM_SRC   (NUM_SRC),
        .ADDR_W    (ADDR_W),
        .EDGE_MASK (32'hF000_0000)
    ) i_plic_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_re_i    (re),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [ADDR_W-1:0] pa(input int id);
        return ADDR_W'(id * 4);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        check("R1 irq", {31'd0, irq}, 32'd0);
        rd_chk("R1 prio5", pa(5), 32'd0);
        rd_chk("R1 enable", A_ENA, 32'd0);
        rd_chk("R1 thr", A_THR, 32'd0);
        rd_chk("R1 claim", A_CLM, 32'd0);
    endtask

    task automatic t_regs();
        wr(pa(3), 32'hFFFF_FFFD);
        rd_chk("R2 prio low bits", pa(3), 32'd5);
        wr(pa(0), 32'd7);
        rd_chk("R2 prio id0", pa(0), 32'd0);
        wr(A_ENA, 32'hFFFF_FFFF);
        rd_chk("R3 enable bit0", A_ENA, 32'hFFFF_FFFE);
        wr(A_ENA, 32'd0);
        wr(pa(3), 32'd0);
    endtask

    task automatic t_gating();
        wr(pa(2), 32'd0);
        wr(pa(4), 32'd3);
        wr(A_ENA, 32'h0000_0004);
        src[2] = 1'b1; src[4] = 1'b1;
        step(3);
        check("R4 masked irq", {31'd0, irq}, 32'd0);
        rd_chk("R4 masked claim", A_CLM, 32'd0);
        wr(A_ENA, 32'h0000_0014);
        step(2);
        check("R4 enabled irq", {31'd0, irq}, 32'd1);
        rd_chk("R7 claim id", A_CLM, 32'd4);
        step(2);
        check("R8 no repend irq", {31'd0, irq}, 32'd0);
        rd_chk("R8 no repend claim", A_CLM, 32'd0);
        wr(A_CLM, 32'd4);
        step(2);
        check("R8 repend irq", {31'd0, irq}, 32'd1);
        rd_chk("R8 repend claim", A_CLM, 32'd4);
        src[2] = 1'b0; src[4] = 1'b0;
        wr(A_CLM, 32'd4);
        wr(pa(2), 32'd1);
        rd_chk("R4 prio0 later wins", A_CLM, 32'd2);
        wr(A_CLM, 32'd2);
        wr(A_ENA, 32'd0);
    endtask

    task automatic t_threshold();
        wr(pa(5), 32'd3);
        wr(A_ENA, 32'h0000_0020);
        wr(A_THR, 32'd3);
        src[5] = 1'b1;
        step(3);
        check("R5 equal masked irq", {31'd0, irq}, 32'd0);
        rd_chk("R5 equal masked claim", A_CLM, 32'd0);
        wr(A_THR, 32'd2);
        step(2);
        check("R5 above passes", {31'd0, irq}, 32'd1);
        wr(A_THR, 32'd7);
        step(2);
        check("R5 thr7 masks", {31'd0, irq}, 32'd0);
        wr(pa(5), 32'd7);
        step(2);
        check("R5 prio7 thr7 masked", {31'd0, irq}, 32'd0);
        wr(A_THR, 32'd0);
        step(2);
        check("R5 thr0 passes", {31'd0, irq}, 32'd1);
        // both strobes: write of id 0 only, no claim
        addr = A_CLM; wdata = 32'd0; we = 1'b1; re = 1'b1;
        @(negedge clk);
        we = 1'b0; re = 1'b0;
        rd_chk("R13 claim survives dual strobe", A_CLM, 32'd5);
        src[5] = 1'b0;
        wr(A_CLM, 32'd5);
        wr(A_ENA, 32'd0);
    endtask

    task automatic t_arbitration();
        wr(pa(7), 32'd2);
        wr(pa(9), 32'd6);
        wr(pa(12), 32'd6);
        wr(A_ENA, (32'd1 << 7) | (32'd1 << 9) | (32'd1 << 12));
        src[7] = 1'b1; src[9] = 1'b1; src[12] = 1'b1;
        step(2);
        rd_chk("R6 tie lowest id", A_CLM, 32'd9);
        rd_chk("R6 tie next", A_CLM, 32'd12);
        rd_chk("R6 lower prio last", A_CLM, 32'd7);
        rd_chk("R7 none left", A_CLM, 32'd0);
        src[7] = 1'b0; src[9] = 1'b0; src[12] = 1'b0;
        wr(A_CLM, 32'd12);
        wr(A_CLM, 32'd7);
        wr(A_CLM, 32'd9);
        wr(A_ENA, 32'd0);
    endtask

    task automatic t_completion();
        wr(pa(10), 32'd4);
        wr(pa(11), 32'd4);
        wr(A_ENA, (32'd1 << 10) | (32'd1 << 11));
        src[10] = 1'b1; src[11] = 1'b1;
        step(2);
        rd_chk("R9 first claim", A_CLM, 32'd10);
        rd_chk("R9 second claim", A_CLM, 32'd11);
        wr(A_CLM, 32'd10);
        step(2);
        rd_chk("R9 older id completed", A_CLM, 32'd10);
        wr(A_ENA, 32'd1 << 10);
        wr(A_CLM, 32'd11);
        wr(A_CLM, 32'd40);
        wr(A_ENA, (32'd1 << 10) | (32'd1 << 11));
        step(2);
        check("R10 disabled cmpl ignored irq", {31'd0, irq}, 32'd0);
        rd_chk("R10 disabled cmpl ignored claim", A_CLM, 32'd0);
        wr(A_CLM, 32'd11);
        step(2);
        rd_chk("R10 enabled cmpl works", A_CLM, 32'd11);
        src[10] = 1'b0; src[11] = 1'b0;
        wr(A_CLM, 32'd10);
        wr(A_CLM, 32'd11);
        wr(A_ENA, 32'd0);
    endtask

    task automatic t_edge();
        wr(pa(29), 32'd5);
        wr(A_ENA, 32'd1 << 29);
        src[29] = 1'b1;
        step(2);
        check("R12 edge raises irq", {31'd0, irq}, 32'd1);
        rd_chk("R12 edge claim", A_CLM, 32'd29);
        wr(A_CLM, 32'd29);
        step(3);
        rd_chk("R12 held high no repend", A_CLM, 32'd0);
        src[29] = 1'b0; step(1);
        src[29] = 1'b1; step(1);
        rd_chk("R12 new edge pends", A_CLM, 32'd29);
        src[29] = 1'b0; step(1);
        src[29] = 1'b1; step(1);
        wr(A_CLM, 32'd29);
        step(3);
        rd_chk("R12 edge in service lost", A_CLM, 32'd0);
        src[29] = 1'b0;
        wr(A_ENA, 32'd0);
    endtask

    task automatic t_overlap();
        logic [31:0] d;
        wr(pa(14), 32'd2);
        wr(pa(13), 32'd5);
        wr(A_ENA, (32'd1 << 13) | (32'd1 << 14));
        src[14] = 1'b1;
        step(1);
        check("R11 irq not yet", {31'd0, irq}, 32'd0);
        step(1);
        check("R11 irq one cycle later", {31'd0, irq}, 32'd1);
        // new higher request arrives in the claim cycle
        addr = A_CLM; re = 1'b1; src[13] = 1'b1;
        @(negedge clk);
        re = 1'b0;
        check("R7 claim sees prior winner", rdata, 32'd14);
        check("R11 irq holds", {31'd0, irq}, 32'd1);
        rd(A_CLM, d);
        check("R6 newcomer next", d, 32'd13);
        check("R11 irq lags claim", {31'd0, irq}, 32'd1);
        step(1);
        check("R11 irq falls", {31'd0, irq}, 32'd0);
        src[13] = 1'b0; src[14] = 1'b0;
        wr(A_CLM, 32'd13);
        wr(A_CLM, 32'd14);
        wr(A_ENA, 32'd0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regs();
        t_gating();
        t_threshold();
        t_arbitration();
        t_completion();
        t_edge();
        t_overlap();
        step(2);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule